// File: doc/BRIEF.md
# Barker Correlator Differential Despreader

This block is the bit decision stage of a direct-sequence spread-spectrum receiver running at the 1 and 2 Mbit/s rates. It takes one soft chip per `chip_vld` strobe as a signed in-phase and quadrature pair. It folds every eleven accepted chips into one complex symbol estimate by adding or subtracting each sample according to the 11-chip Barker spreading code. It then compares that estimate with the one from the symbol before. The phase step between the two estimates gives one bit in binary differential mode or two bits in quadrature differential mode.

Symbol timing, carrier recovery and descrambling happen upstream or downstream of this block. An upstream stage marks the first chip of a symbol-aligned burst with `chip_sync`. The block restarts its chip count on that marker and drops any reference it held. The first complete symbol after the marker therefore only becomes the phase reference for the next symbol. Decided bits leave one at a time, each with a one-cycle `bit_vld` pulse.

Top module: `barker_diff_despreader`

## Requirements
- R1: While `rst` is high, and after it falls, `bit_vld` is 0. The first complete symbol after reset acts as a phase reference, just as one after `chip_sync` does.
- R2: Chip k of a symbol (k = 0 first, up to 10) is weighted by code value c[k] from the code +1 −1 +1 +1 −1 +1 +1 +1 −1 −1 −1, where +1 adds the sample and −1 subtracts it. Full-scale 8-bit samples on all eleven chips correlate without wrap-around.
- R3: The first complete symbol after `chip_sync` produces no bits.
- R4: With `rate_2m` = 0, each later symbol gives one bit. The bit is 0 when the real part of current × conj(previous) is zero or positive, and 1 when it is negative.
- R5: With `rate_2m` = 1, the phase step (0°, 90°, 180° or 270°) maps to the bit pairs 00, 01, 11 and 10. The quadrant comes from whichever of the real and imaginary parts has the larger magnitude, and that part's sign. When the two magnitudes are equal, the real axis is chosen.
- R6: In quadrature mode the left bit of the pair goes out first, and the right bit follows in the very next cycle.
- R7: The first bit of a symbol is valid for one cycle, starting two clock edges after the edge that accepts the symbol's last chip.
- R8: `chip_sync` together with `chip_vld` restarts the chip count at that chip. The partial symbol and the previous reference are both discarded.
- R9: While `chip_vld` is 0, the sample and `chip_sync` inputs are ignored and the chip count does not advance.
- R10: `rate_2m` is sampled on the clock edge after the one that accepts a symbol's last chip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_vld | input | 1 | Chip strobe; the sample inputs hold a chip |
| chip_sync | input | 1 | With `chip_vld`, marks the first chip of a new burst |
| chip_i | input | 8 | Signed in-phase soft chip |
| chip_q | input | 8 | Signed quadrature soft chip |
| rate_2m | input | 1 | 0: one bit per symbol, 1: two bits per symbol |
| bit_vld | output | 1 | One-cycle pulse per decided bit |
| bit_out | output | 1 | Decided bit |

## Verification
The bench drives symbols whose four phases sit well off the axes and carry small per-chip noise. A design that decided on absolute phase instead of the change between symbols, or that mixed up the 90° and 270° codes, would produce wrong bit pairs. Chips are spread out with idle cycles that carry garbage samples and a raised sync line. This exposes a counter that advances, or restarts, when no chip is valid. A burst is broken off mid-symbol with a new sync, which shows whether leftover partial sums or a stale reference survive. Equal-magnitude products of both signs test the tie rule. Full-scale chips reveal an accumulator that is too narrow. The exact cycle of each bit in a pair is measured, which catches a design that swaps the order of the two bits or adds a register stage.

// File: rtl/despread_pkg.sv
package despread_pkg;

    localparam int CODE_LEN = 11;
    // bit k set: chip k of the code is +1 (chip 0 is the first one received)
    localparam logic [CODE_LEN-1:0] CODE_PLUS = 11'b000_1110_1101;

    typedef enum logic [1:0] {
        PH_0   = 2'd0,
        PH_90  = 2'd1,
        PH_180 = 2'd2,
        PH_270 = 2'd3
    } phase_e;

    typedef struct packed {
        logic   vld;
        logic   pair;
        phase_e phase;
    } decision_t;

    function automatic logic [1:0] phase_to_dibit(input phase_e p);
        case (p)
            PH_0:    return 2'b00;
            PH_90:   return 2'b01;
            PH_180:  return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    function automatic phase_e pick_phase(input logic re_neg, input logic im_neg,
                                          input logic im_dominant, input logic pair);
        if (!pair || !im_dominant)
            return re_neg ? PH_180 : PH_0;
        return im_neg ? PH_270 : PH_90;
    endfunction

endpackage

// File: rtl/despread_correlator.sv
module despread_correlator
    import despread_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int ACC_W    = SAMPLE_W + 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       chip_vld,
    input  logic                       chip_sync,
    input  logic signed [SAMPLE_W-1:0] chip_i,
    input  logic signed [SAMPLE_W-1:0] chip_q,
    output logic                       sym_vld,
    output logic                       sym_first,
    output logic signed [ACC_W-1:0]    sym_i,
    output logic signed [ACC_W-1:0]    sym_q
);
    localparam int IDX_W = $clog2(CODE_LEN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CODE_LEN - 1);

    logic [IDX_W-1:0]        idx_q, idx_eff;
    logic                    fresh_q, fresh_eff, code_bit;
    logic signed [ACC_W-1:0] acc_i_q, acc_q_q;
    logic signed [ACC_W-1:0] base_i, base_q, term_i, term_q, next_i, next_q;

    always_comb begin
        idx_eff   = chip_sync ? '0 : idx_q;
        fresh_eff = chip_sync | fresh_q;
        code_bit  = CODE_PLUS[idx_eff];
        base_i    = (idx_eff == '0) ? '0 : acc_i_q;
        base_q    = (idx_eff == '0) ? '0 : acc_q_q;
        term_i    = code_bit ? ACC_W'(chip_i) : -ACC_W'(chip_i);
        term_q    = code_bit ? ACC_W'(chip_q) : -ACC_W'(chip_q);
        next_i    = base_i + term_i;
        next_q    = base_q + term_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q     <= '0;
            fresh_q   <= 1'b1;
            acc_i_q   <= '0;
            acc_q_q   <= '0;
            sym_vld   <= 1'b0;
            sym_first <= 1'b0;
            sym_i     <= '0;
            sym_q     <= '0;
        end else begin
            sym_vld <= 1'b0;
            if (chip_vld) begin
                if (idx_eff == LAST_IDX) begin
                    sym_vld   <= 1'b1;
                    sym_first <= fresh_eff;
                    sym_i     <= next_i;
                    sym_q     <= next_q;
                    fresh_q   <= 1'b0;
                    idx_q     <= '0;
                end else begin
                    acc_i_q <= next_i;
                    acc_q_q <= next_q;
                    fresh_q <= fresh_eff;
                    idx_q   <= idx_eff + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/despread_phase_detect.sv
module despread_phase_detect
    import despread_pkg::*;
#(
    parameter int ACC_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sym_vld,
    input  logic                    sym_first,
    input  logic signed [ACC_W-1:0] sym_i,
    input  logic signed [ACC_W-1:0] sym_q,
    input  logic                    rate_2m,
    output decision_t               dec
);
    localparam int PROD_W = 2 * ACC_W + 2;

    logic signed [ACC_W-1:0]  ref_i, ref_q;
    logic signed [PROD_W-1:0] re, im, mag_re, mag_im;
    logic                     im_dom;

    // current estimate times the conjugate of the reference
    always_comb begin
        re     = PROD_W'(sym_i) * PROD_W'(ref_i) + PROD_W'(sym_q) * PROD_W'(ref_q);
        im     = PROD_W'(sym_q) * PROD_W'(ref_i) - PROD_W'(sym_i) * PROD_W'(ref_q);
        mag_re = re[PROD_W-1] ? -re : re;
        mag_im = im[PROD_W-1] ? -im : im;
        im_dom = mag_im > mag_re;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_i <= '0;
            ref_q <= '0;
            dec   <= '0;
        end else begin
            dec.vld <= 1'b0;
            if (sym_vld) begin
                ref_i <= sym_i;
                ref_q <= sym_q;
                if (!sym_first) begin
                    dec.vld   <= 1'b1;
                    dec.pair  <= rate_2m;
                    dec.phase <= pick_phase(re[PROD_W-1], im[PROD_W-1], im_dom, rate_2m);
                end
            end
        end
    end

endmodule

// File: rtl/despread_serializer.sv
module despread_serializer
    import despread_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  decision_t dec,
    output logic      bit_vld,
    output logic      bit_out
);
    logic [1:0] dibit;
    logic       pend_vld, pend_bit;

    always_comb dibit = phase_to_dibit(dec.phase);

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_vld  <= 1'b0;
            bit_out  <= 1'b0;
            pend_vld <= 1'b0;
            pend_bit <= 1'b0;
        end else if (dec.vld) begin
            bit_vld  <= 1'b1;
            bit_out  <= dec.pair ? dibit[1] : (dec.phase == PH_180);
            pend_vld <= dec.pair;
            pend_bit <= dibit[0];
        end else if (pend_vld) begin
            bit_vld  <= 1'b1;
            bit_out  <= pend_bit;
            pend_vld <= 1'b0;
        end else begin
            bit_vld <= 1'b0;
        end
    end

endmodule

// File: rtl/barker_diff_despreader.sv
module barker_diff_despreader
    import despread_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int ACC_W    = SAMPLE_W + 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       chip_vld,
    input  logic                       chip_sync,
    input  logic signed [SAMPLE_W-1:0] chip_i,
    input  logic signed [SAMPLE_W-1:0] chip_q,
    input  logic                       rate_2m,
    output logic                       bit_vld,
    output logic                       bit_out
);
    logic                    sym_vld, sym_first;
    logic signed [ACC_W-1:0] sym_i, sym_q;
    decision_t               dec;

    despread_correlator #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_corr (
        .clk       (clk),
        .rst       (rst),
        .chip_vld  (chip_vld),
        .chip_sync (chip_sync),
        .chip_i    (chip_i),
        .chip_q    (chip_q),
        .sym_vld   (sym_vld),
        .sym_first (sym_first),
        .sym_i     (sym_i),
        .sym_q     (sym_q)
    );

    despread_phase_detect #(.ACC_W(ACC_W)) u_phase (
        .clk       (clk),
        .rst       (rst),
        .sym_vld   (sym_vld),
        .sym_first (sym_first),
        .sym_i     (sym_i),
        .sym_q     (sym_q),
        .rate_2m   (rate_2m),
        .dec       (dec)
    );

    despread_serializer u_ser (
        .clk     (clk),
        .rst     (rst),
        .dec     (dec),
        .bit_vld (bit_vld),
        .bit_out (bit_out)
    );

endmodule

// File: rtl/despread_checker.sv
module despread_checker (
    input logic clk,
    input logic rst,
    input logic sym_vld,
    input logic sym_first,
    input logic dec_vld,
    input logic dec_pair,
    input logic bit_vld
);
    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !bit_vld); // R1

    AST_SYM_SPACING: assert property (@(posedge clk) disable iff (rst)
        sym_vld |=> !sym_vld); // R2

    AST_FIRST_SILENT: assert property (@(posedge clk) disable iff (rst)
        (sym_vld && sym_first) |=> !dec_vld); // R3

    AST_LATER_DECIDES: assert property (@(posedge clk) disable iff (rst)
        (sym_vld && !sym_first) |=> dec_vld); // R4

    AST_SINGLE_BIT: assert property (@(posedge clk) disable iff (rst)
        (dec_vld && !dec_pair) |=> ##1 !bit_vld); // R4

    AST_PAIR_SECOND: assert property (@(posedge clk) disable iff (rst)
        (dec_vld && dec_pair) |=> ##1 bit_vld); // R6

    AST_DEC_TO_BIT: assert property (@(posedge clk) disable iff (rst)
        dec_vld |=> bit_vld); // R7
endmodule

bind barker_diff_despreader despread_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .sym_vld   (sym_vld),
    .sym_first (sym_first),
    .dec_vld   (dec.vld),
    .dec_pair  (dec.pair),
    .bit_vld   (bit_vld)
);

// File: tb/barker_diff_despreader_tb.sv
`timescale 1ns/1ps
module barker_diff_despreader_tb;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              chip_vld = 1'b0;
    logic              chip_sync = 1'b0;
    logic              rate_2m = 1'b0;
    logic signed [7:0] chip_i = '0;
    logic signed [7:0] chip_q = '0;
    logic              bit_vld, bit_out;

    always #2 clk = ~clk;

    barker_diff_despreader u_dut (
        .clk(clk), .rst(rst), .chip_vld(chip_vld), .chip_sync(chip_sync),
        .chip_i(chip_i), .chip_q(chip_q), .rate_2m(rate_2m),
        .bit_vld(bit_vld), .bit_out(bit_out)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int    n_tests = 0, n_fail = 0;
    int    code [11] = '{1, -1, 1, 1, -1, 1, 1, 1, -1, -1, -1};

    logic  obs_bit   [256];
    int    obs_stamp [256];
    int    obs_n = 0;
    logic  exp_bit   [256];
    string exp_tag   [256];
    int    exp_n = 0;
    int    last_cyc = 0;

    always @(negedge clk) begin
        if (!rst && bit_vld && obs_n < 256) begin
            obs_bit[obs_n]   = bit_out;
            obs_stamp[obs_n] = cyc;
            obs_n++;
        end
    end

    // table rows: {rate_2m, gap, phase step}; step 0..3 = 0/90/180/270 degrees
    localparam logic [3:0] VEC [12] = '{
        4'b0000, 4'b0010, 4'b0100, 4'b0010, 4'b0110, 4'b1001,
        4'b1111, 4'b1010, 4'b1000, 4'b1101, 4'b0000, 4'b1011
    };

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic push_exp(input logic b, input string tag);
        exp_bit[exp_n] = b;
        exp_tag[exp_n] = tag;
        exp_n++;
    endtask

    task automatic push_step(input logic pair, input int step, input string tag);
        if (!pair) push_exp(step == 2, tag);
        else begin
            case (step)
                0: begin push_exp(1'b0, tag); push_exp(1'b0, tag); end
                1: begin push_exp(1'b0, tag); push_exp(1'b1, tag); end
                2: begin push_exp(1'b1, tag); push_exp(1'b1, tag); end
                default: begin push_exp(1'b1, tag); push_exp(1'b0, tag); end
            endcase
        end
    endtask

    task automatic drive(input logic v, input logic s, input int i, input int q);
        @(negedge clk);
        chip_vld  = v;
        chip_sync = s;
        chip_i    = 8'(i);
        chip_q    = 8'(q);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) drive(1'b0, 1'b0, 0, 0);
    endtask

    task automatic send_chips(input int si, input int sq, input bit first,
                              input bit gap, input bit noisy, input int nchips);
        for (int k = 0; k < nchips; k++) begin
            int ni;
            if (gap && (k % 4 == 2)) drive(1'b0, 1'b1, 99, -99);
            ni = noisy ? (k % 3) - 1 : 0;
            drive(1'b1, first && (k == 0), code[k] * si + ni, code[k] * sq);
            last_cyc = cyc + 1;
        end
    endtask

    task automatic send_sym(input int si, input int sq, input bit first,
                            input bit gap, input bit noisy);
        send_chips(si, sq, first, gap, noisy, 11);
    endtask

    task automatic vec_of(input int p, input int a, input int b, output int vi, output int vq);
        case (p)
            0: begin vi = a;  vq = b;  end
            1: begin vi = -b; vq = a;  end
            2: begin vi = -a; vq = -b; end
            default: begin vi = b; vq = -a; end
        endcase
    endtask

    task automatic check_seg(input int o0, input int e0, input string req);
        int no, ne;
        no = obs_n - o0;
        ne = exp_n - e0;
        check(no == ne, {req, " bit count"}, no, ne);
        for (int k = 0; k < ((no < ne) ? no : ne); k++)
            check(obs_bit[o0 + k] === exp_bit[e0 + k], exp_tag[e0 + k],
                  int'(obs_bit[o0 + k]), int'(exp_bit[e0 + k]));
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        finish_run();
    end

    initial begin
        int o0, e0, ph, vi, vq, len;
        logic [3:0] row;

        // R1: quiet in and after reset
        repeat (3) @(negedge clk);
        check(bit_vld == 1'b0, "R1 in reset", int'(bit_vld), 0);
        rst = 1'b0;
        idle(4);
        check(bit_vld == 1'b0, "R1 after reset", int'(bit_vld), 0);

        // table walk: R4, R5, R9 (gap rows), R10 (rate per symbol)
        o0 = obs_n; e0 = exp_n; ph = 0;
        for (int r = 0; r < 12; r++) begin
            row = VEC[r];
            rate_2m = row[3];
            ph = (ph + int'(row[1:0])) % 4;
            vec_of(ph, 20, 6, vi, vq);
            send_sym(vi, vq, r == 0, row[2], 1'b1);
            if (r > 0)
                push_step(row[3], int'(row[1:0]),
                          row[2] ? (row[3] ? "R5 R9 R10" : "R4 R9 R10")
                                 : (row[3] ? "R5 R10" : "R4 R10"));
            idle(2);
        end
        idle(6);
        check_seg(o0, e0, "R4 R5 table");

        // R6 and R7: pair order and exact cycles
        rate_2m = 1'b1;
        o0 = obs_n;
        send_sym(20, 6, 1'b1, 1'b0, 1'b0);
        idle(2);
        send_sym(-6, 20, 1'b0, 1'b0, 1'b0);
        len = last_cyc;
        idle(6);
        check(obs_n - o0 == 2, "R6 pair count", obs_n - o0, 2);
        check(obs_stamp[o0] == len + 2, "R7 first bit cycle", obs_stamp[o0], len + 2);
        check(obs_stamp[o0 + 1] == obs_stamp[o0] + 1, "R6 second bit cycle",
              obs_stamp[o0 + 1], obs_stamp[o0] + 1);
        check(obs_bit[o0] == 1'b0, "R6 left bit", int'(obs_bit[o0]), 0);
        check(obs_bit[o0 + 1] == 1'b1, "R6 right bit", int'(obs_bit[o0 + 1]), 1);

        // R5 ties go to the real axis, both signs
        o0 = obs_n; e0 = exp_n;
        send_sym(40, 0, 1'b1, 1'b0, 1'b0);   idle(2);
        send_sym(40, 40, 1'b0, 1'b0, 1'b0);  idle(2);
        push_step(1'b1, 0, "R5 tie positive");
        send_sym(40, 0, 1'b1, 1'b0, 1'b0);   idle(2);
        send_sym(-40, 40, 1'b0, 1'b0, 1'b0); idle(6);
        push_step(1'b1, 2, "R5 tie negative");
        check_seg(o0, e0, "R5 ties");

        // R8: sync in mid-symbol drops partial sum and reference
        rate_2m = 1'b0;
        o0 = obs_n; e0 = exp_n;
        send_sym(20, 6, 1'b1, 1'b0, 1'b1);   idle(2);
        send_chips(-20, -6, 1'b0, 1'b0, 1'b1, 6);
        send_sym(-6, 20, 1'b1, 1'b0, 1'b1);  idle(2);
        send_sym(-6, 20, 1'b0, 1'b0, 1'b1);  idle(2);
        push_step(1'b0, 0, "R8 after restart");
        send_sym(6, -20, 1'b0, 1'b0, 1'b1);  idle(6);
        push_step(1'b0, 2, "R8 after restart");
        check_seg(o0, e0, "R8");

        // R3: a lone symbol after sync gives nothing
        o0 = obs_n;
        send_sym(20, 6, 1'b1, 1'b0, 1'b1);
        idle(8);
        check(obs_n == o0, "R3 lone reference", obs_n - o0, 0);

        // R2: full-scale chips, both rates
        o0 = obs_n; e0 = exp_n;
        send_sym(127, 0, 1'b1, 1'b0, 1'b0);  idle(2);
        send_sym(-127, 0, 1'b0, 1'b0, 1'b0); idle(2);
        push_step(1'b0, 2, "R2 full scale");
        rate_2m = 1'b1;
        send_sym(0, -127, 1'b0, 1'b0, 1'b0); idle(2);
        push_step(1'b1, 1, "R2 full scale");
        send_sym(127, 0, 1'b0, 1'b0, 1'b0);  idle(6);
        push_step(1'b1, 1, "R2 full scale");
        check_seg(o0, e0, "R2");

        // R1: reset in mid-burst; next symbol is a reference without sync
        rate_2m = 1'b0;
        send_sym(20, 6, 1'b1, 1'b0, 1'b0);   idle(2);
        send_chips(-20, -6, 1'b0, 1'b0, 1'b0, 5);
        @(negedge clk);
        rst = 1'b1; chip_vld = 1'b0;
        repeat (3) @(negedge clk);
        check(bit_vld == 1'b0, "R1 mid-run reset", int'(bit_vld), 0);
        rst = 1'b0;
        o0 = obs_n; e0 = exp_n;
        send_sym(20, 6, 1'b0, 1'b0, 1'b0);   idle(2);
        send_sym(-20, -6, 1'b0, 1'b0, 1'b0); idle(6);
        push_step(1'b0, 2, "R1 reference after reset");
        check_seg(o0, e0, "R1");

        finish_run();
    end

endmodule